// File: doc/BRIEF.md
# Three-Level Interrupt Aggregation Tree

This block collects event pulses into sticky leaf status registers, each guarded by its own mask. Every leaf register folds its masked bits into one bit of a middle-tier register, and every middle-tier register folds its masked bits into one bit of a single top register. The masked top register becomes the one interrupt line of the device. Software finds a source by reading the top register, then the middle register its bit names, then that leaf. It clears the event by writing ones to the leaf status.

Two wake sources feed leaf 0 without needing any clock of their own. A rising edge on a serial bus line is caught by a flop clocked by that line. A wake pin pulled low is caught by a flop clocked by the inverted pin. Each catch is synchronized into the register clock, turned into a single event and cleared again by a handshake. The register port is plain: a write strobe, an address, write data and a combinational read-data output.

Top module: `irq_tree_top`

## Requirements
- R1: After reset every status and mask register reads 0 and `irq_o` is low.
- R2: A one on bit j of `ev_i` in a cycle sets leaf status bit j mod LEAF_W of leaf j / LEAF_W at that clock edge. The bit stays set after the event goes away.
- R3: A write to a leaf status address clears the bits written as one and leaves the bits written as zero. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: Bit b of middle register g is high exactly when leaf g*MID_W+b has a bit that is set in both its status and its mask. The middle bit drops on its own once that leaf is cleared.
- R5: Top status bit g is high exactly when middle register g has a bit set in both its status and its mask.
- R6: `irq_o` is high exactly when some top status bit is set and also enabled in the top mask.
- R7: Each mask reads back the low bits of the last value written to it, as many bits as that register has. Writes to top or middle status addresses have no effect.
- R8: Address map: 0 is top status, 1 is top mask, 2+2g and 3+2g are the status and mask of middle register g. With B = 2+2*N_MID, B+2k and B+2k+1 are the status and mask of leaf k. Any other address reads 0.
- R9: A rising edge on `bus_line_i` sets leaf 0 bit 0 within five register clocks once the clock runs. The edge is caught even while the register clock is stopped.
- R10: A high-to-low transition on `wake_pin_n_i` sets leaf 0 bit 1 once. Holding the pin low does not set the bit again after it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_i | input | N_MID*MID_W*LEAF_W | Per-source event pulses, leaf-major |
| bus_line_i | input | 1 | Serial bus line watched for activity |
| wake_pin_n_i | input | 1 | Wake pin, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Device interrupt request |

## Verification
The bench fires every leaf bit in turn and checks which middle and top bits light up. A design with mis-wired summary indices would light the wrong bit. It sweeps every mask value at each tier, which catches a mask that is inverted or ignored. It fires an event and a clear on the same bit in the same cycle: a design that lets the clear win would lose that event. It pulses the bus line while the bench clock is stopped, so a catch that depends on the register clock would miss the wake. It holds the wake pin low after a clear, so level-sensitive detection would fire the event again.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;

  typedef enum logic [1:0] {RK_NONE, RK_STAT, RK_MASK} reg_kind_e;
  typedef enum logic [1:0] {LV_TOP, LV_MID, LV_LEAF} reg_lvl_e;

  typedef struct packed {
    reg_lvl_e  lvl;
    reg_kind_e kind;
    logic [7:0] idx;
  } reg_sel_t;

  // Map an address onto tier, register kind and index within the tier.
  function automatic reg_sel_t decode_addr(input int unsigned a,
                                           input int unsigned n_mid,
                                           input int unsigned n_leaf);
    reg_sel_t s;
    int unsigned leaf_base;
    leaf_base = 2 + 2 * n_mid;
    s.lvl  = LV_TOP;
    s.kind = RK_NONE;
    s.idx  = '0;
    if (a < 2) begin
      s.kind = (a == 0) ? RK_STAT : RK_MASK;
    end else if (a < leaf_base) begin
      s.lvl  = LV_MID;
      s.kind = ((a - 2) % 2 == 0) ? RK_STAT : RK_MASK;
      s.idx  = 8'((a - 2) / 2);
    end else if (a < leaf_base + 2 * n_leaf) begin
      s.lvl  = LV_LEAF;
      s.kind = ((a - leaf_base) % 2 == 0) ? RK_STAT : RK_MASK;
      s.idx  = 8'((a - leaf_base) / 2);
    end
    return s;
  endfunction

endpackage

// File: rtl/irq_leaf_reg.sv
module irq_leaf_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_i,
  input  logic [W-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_d_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         sum_o
);
  logic [W-1:0] stat_q, mask_q;

  // Sticky bits: a new event outranks a same-cycle clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_i) | ev_i;
      if (mask_we_i) mask_q <= mask_d_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign sum_o  = |(stat_q & mask_q);
endmodule

// File: rtl/irq_mid_reg.sv
module irq_mid_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_d_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         sum_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_d_i;
  end

  // Live status: follows the masked summaries below with no storage.
  assign stat_o = in_i;
  assign mask_o = mask_q;
  assign sum_o  = |(in_i & mask_q);
endmodule

// File: rtl/irq_wake_cell.sv
module irq_wake_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  logic cap_q;
  logic s1_q, s2_q, s3_q, clr_q;
  logic clr_w;

  assign clr_w = clr_q | ~rst_n;

  // Capture flop clocked by the wake signal itself; no register clock needed.
  always_ff @(posedge trig_i or posedge clr_w) begin
    if (clr_w) cap_q <= 1'b0;
    else       cap_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      s1_q  <= cap_q;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      clr_q <= s2_q;
    end
  end

  assign pulse_o = s2_q & ~s3_q;
endmodule

// File: rtl/irq_tree_top.sv
module irq_tree_top
  import irq_tree_pkg::*;
#(
  parameter int N_MID  = 2,
  parameter int MID_W  = 2,
  parameter int LEAF_W = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N_MID*MID_W*LEAF_W-1:0]    ev_i,
  input  logic                             bus_line_i,
  input  logic                             wake_pin_n_i,
  input  logic                             reg_wr_i,
  input  logic [ADDR_W-1:0]                reg_addr_i,
  input  logic [DATA_W-1:0]                reg_wdata_i,
  output logic [DATA_W-1:0]                reg_rdata_o,
  output logic                             irq_o
);
  localparam int N_LEAF = N_MID * MID_W;
  localparam int N_EV   = N_LEAF * LEAF_W;

  reg_sel_t sel;
  logic [N_EV-1:0]        leaf_ev;
  logic [N_EV-1:0]        leaf_stat_all, leaf_mask_all, leaf_clr_all;
  logic [N_LEAF-1:0]      leaf_sum;
  logic [N_LEAF-1:0]      mid_stat_all, mid_mask_all;
  logic [N_MID-1:0]       mid_sum;
  logic [N_MID-1:0]       top_stat, top_mask;
  logic                   top_sum;
  logic                   wake_bus, wake_pin;

  assign sel = decode_addr(int'(reg_addr_i), N_MID, N_LEAF);

  // Wake sources.
  irq_wake_cell u_wake_bus (.clk(clk), .rst_n(rst_n), .trig_i(bus_line_i),    .pulse_o(wake_bus));
  irq_wake_cell u_wake_pin (.clk(clk), .rst_n(rst_n), .trig_i(~wake_pin_n_i), .pulse_o(wake_pin));

  always_comb begin
    leaf_ev    = ev_i;
    leaf_ev[0] = ev_i[0] | wake_bus;
    leaf_ev[1] = ev_i[1] | wake_pin;
  end

  // Level 3: sticky leaves.
  for (genvar k = 0; k < N_LEAF; k++) begin : g_leaf
    logic hit_stat, hit_mask;
    assign hit_stat = reg_wr_i && sel.lvl == LV_LEAF && sel.kind == RK_STAT && sel.idx == 8'(k);
    assign hit_mask = reg_wr_i && sel.lvl == LV_LEAF && sel.kind == RK_MASK && sel.idx == 8'(k);
    assign leaf_clr_all[k*LEAF_W +: LEAF_W] = hit_stat ? reg_wdata_i[LEAF_W-1:0] : '0;
    irq_leaf_reg #(.W(LEAF_W)) u_leaf (
      .clk(clk), .rst_n(rst_n),
      .ev_i(leaf_ev[k*LEAF_W +: LEAF_W]),
      .clr_i(leaf_clr_all[k*LEAF_W +: LEAF_W]),
      .mask_we_i(hit_mask),
      .mask_d_i(reg_wdata_i[LEAF_W-1:0]),
      .stat_o(leaf_stat_all[k*LEAF_W +: LEAF_W]),
      .mask_o(leaf_mask_all[k*LEAF_W +: LEAF_W]),
      .sum_o(leaf_sum[k])
    );
  end

  // Level 2: live summaries of leaves.
  for (genvar g = 0; g < N_MID; g++) begin : g_mid
    logic hit_mask;
    assign hit_mask = reg_wr_i && sel.lvl == LV_MID && sel.kind == RK_MASK && sel.idx == 8'(g);
    irq_mid_reg #(.W(MID_W)) u_mid (
      .clk(clk), .rst_n(rst_n),
      .in_i(leaf_sum[g*MID_W +: MID_W]),
      .mask_we_i(hit_mask),
      .mask_d_i(reg_wdata_i[MID_W-1:0]),
      .stat_o(mid_stat_all[g*MID_W +: MID_W]),
      .mask_o(mid_mask_all[g*MID_W +: MID_W]),
      .sum_o(mid_sum[g])
    );
  end

  // Level 1: top register drives the device request.
  logic top_mask_we;
  assign top_mask_we = reg_wr_i && sel.lvl == LV_TOP && sel.kind == RK_MASK;

  irq_mid_reg #(.W(N_MID)) u_top (
    .clk(clk), .rst_n(rst_n),
    .in_i(mid_sum),
    .mask_we_i(top_mask_we),
    .mask_d_i(reg_wdata_i[N_MID-1:0]),
    .stat_o(top_stat),
    .mask_o(top_mask),
    .sum_o(top_sum)
  );

  assign irq_o = top_sum;

  // Read mux.
  always_comb begin
    reg_rdata_o = '0;
    if (sel.kind != RK_NONE) begin
      case (sel.lvl)
        LV_TOP:  reg_rdata_o = (sel.kind == RK_STAT) ? DATA_W'(top_stat) : DATA_W'(top_mask);
        LV_MID:  reg_rdata_o = (sel.kind == RK_STAT)
                   ? DATA_W'(mid_stat_all[int'(sel.idx)*MID_W +: MID_W])
                   : DATA_W'(mid_mask_all[int'(sel.idx)*MID_W +: MID_W]);
        LV_LEAF: reg_rdata_o = (sel.kind == RK_STAT)
                   ? DATA_W'(leaf_stat_all[int'(sel.idx)*LEAF_W +: LEAF_W])
                   : DATA_W'(leaf_mask_all[int'(sel.idx)*LEAF_W +: LEAF_W]);
        default: reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_tree_chk.sv
module irq_tree_chk #(
  parameter int N_MID  = 2,
  parameter int MID_W  = 2,
  parameter int LEAF_W = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_wr_i,
  input logic [ADDR_W-1:0]             reg_addr_i,
  input logic [DATA_W-1:0]             reg_wdata_i,
  input logic                          irq_o,
  input logic [N_MID*MID_W*LEAF_W-1:0] leaf_stat_all,
  input logic [N_MID*MID_W*LEAF_W-1:0] leaf_mask_all,
  input logic [N_MID*MID_W*LEAF_W-1:0] leaf_clr_all,
  input logic [N_MID*MID_W-1:0]        mid_stat_all,
  input logic [N_MID*MID_W-1:0]        mid_mask_all,
  input logic [N_MID-1:0]              top_mask
);
  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (top_mask == '0 && mid_mask_all == '0 && leaf_mask_all == '0 && !irq_o));

  assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(leaf_stat_all) & ~$past(leaf_clr_all)) & ~leaf_stat_all) == '0));

  assert_mid_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((leaf_stat_all & leaf_mask_all) == '0) |-> (mid_stat_all == '0));

  assert_no_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (top_mask == '0) |-> !irq_o);

  assert_top_mask_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == ADDR_W'(1)) |=> (top_mask == $past(reg_wdata_i[N_MID-1:0])));
endmodule

bind irq_tree_top irq_tree_chk #(
  .N_MID(N_MID), .MID_W(MID_W), .LEAF_W(LEAF_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .irq_o(irq_o),
  .leaf_stat_all(leaf_stat_all), .leaf_mask_all(leaf_mask_all), .leaf_clr_all(leaf_clr_all),
  .mid_stat_all(mid_stat_all), .mid_mask_all(mid_mask_all), .top_mask(top_mask)
);

// File: tb/sim_irq_tree_top.sv
`timescale 1ns/1ps
module sim_irq_tree_top;
  localparam int N_MID = 2, MID_W = 2, LEAF_W = 4, ADDR_W = 6, DATA_W = 8;
  localparam int N_LEAF = N_MID * MID_W;
  localparam int N_EV = N_LEAF * LEAF_W;
  localparam int LB = 2 + 2 * N_MID;
  localparam int LAST_ADDR = LB + 2 * N_LEAF - 1;

  logic clk = 1'b0, clk_en = 1'b1, rst_n = 1'b0;
  logic [N_EV-1:0] ev = '0;
  logic bus_line = 1'b0, wake_pin_n = 1'b1;
  logic wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always begin
    #10;
    if (clk_en) clk = ~clk;
  end

  irq_tree_top #(.N_MID(N_MID), .MID_W(MID_W), .LEAF_W(LEAF_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .bus_line_i(bus_line), .wake_pin_n_i(wake_pin_n),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input int a, input int d);
    @(negedge clk);
    wr = 1'b1; addr = ADDR_W'(a); wdata = DATA_W'(d);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input int a, output int d);
    @(negedge clk);
    addr = ADDR_W'(a);
    #2;
    d = int'(rdata);
  endtask

  task automatic fire(input int bitpos);
    @(negedge clk);
    ev = '0; ev[bitpos] = 1'b1;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic set_all_masks(input int leafm, input int midm, input int topm);
    for (int k = 0; k < N_LEAF; k++) reg_write(LB + 2*k + 1, leafm);
    for (int g = 0; g < N_MID; g++) reg_write(3 + 2*g, midm);
    reg_write(1, topm);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: clean reset state over the whole map.
    for (int a = 0; a <= LAST_ADDR; a++) begin
      reg_read(a, v);
      check("R1 reset register", v, 0);
    end
    check("R1 reset irq", int'(irq), 0);

    // R2 R3 R4 R5 R6: sweep every source bit through the tree.
    set_all_masks(2**LEAF_W - 1, 2**MID_W - 1, 2**N_MID - 1);
    for (int j = 0; j < N_EV; j++) begin
      int k, b, g, m;
      k = j / LEAF_W; b = j % LEAF_W; g = k / MID_W; m = k % MID_W;
      fire(j);
      reg_read(LB + 2*k, v);     check("R2 leaf sticky", v, 1 << b);
      reg_read(2 + 2*g, v);      check("R4 mid summary", v, 1 << m);
      reg_read(0, v);            check("R5 top summary", v, 1 << g);
      check("R6 irq high", int'(irq), 1);
      reg_write(LB + 2*k, ~(1 << b) & (2**LEAF_W - 1));
      reg_read(LB + 2*k, v);     check("R3 zero bits keep", v, 1 << b);
      reg_write(LB + 2*k, 1 << b);
      reg_read(LB + 2*k, v);     check("R3 w1c clears", v, 0);
      reg_read(2 + 2*g, v);      check("R4 mid auto clear", v, 0);
      reg_read(0, v);            check("R5 top auto clear", v, 0);
      check("R6 irq low", int'(irq), 0);
    end

    // Mask sweeps at each tier, with leaf 2 bit 3 pending (mid 1 bit 0, top bit 1).
    fire(2*LEAF_W + 3);
    for (int mv = 0; mv < 2**LEAF_W; mv++) begin
      reg_write(LB + 2*2 + 1, mv);
      reg_read(2 + 2*1, v);      check("R4 leaf mask sweep", v, (mv >> 3) & 1);
    end
    reg_write(LB + 2*2 + 1, 2**LEAF_W - 1);
    for (int mv = 0; mv < 2**MID_W; mv++) begin
      reg_write(3 + 2*1, mv);
      reg_read(0, v);            check("R5 mid mask sweep", v, (mv & 1) << 1);
    end
    reg_write(3 + 2*1, 2**MID_W - 1);
    for (int mv = 0; mv < 2**N_MID; mv++) begin
      reg_write(1, mv);
      #2;
      check("R6 top mask sweep", int'(irq), (mv >> 1) & 1);
    end
    reg_write(1, 2**N_MID - 1);

    // R7: mask readback width, status writes ignored.
    reg_write(LB + 2*1 + 1, 'hA5);
    reg_read(LB + 2*1 + 1, v);   check("R7 leaf mask readback", v, 'h5);
    reg_write(0, 'hFF);
    reg_read(0, v);              check("R7 top status write ignored", v, 2);
    reg_write(2, 'hFF);
    reg_read(2, v);              check("R7 mid status write ignored", v, 0);
    reg_write(LB + 2*1 + 1, 2**LEAF_W - 1);

    // R8: unmapped address reads zero.
    reg_read(LAST_ADDR + 1, v);  check("R8 unmapped read", v, 0);
    reg_read(2**ADDR_W - 1, v);  check("R8 top of space read", v, 0);
    reg_write(LB + 2*2, 'hF);

    // R3: event and clear on the same bit in one cycle.
    @(negedge clk);
    ev = '0; ev[1*LEAF_W + 2] = 1'b1;
    wr = 1'b1; addr = ADDR_W'(LB + 2*1); wdata = DATA_W'(4);
    @(negedge clk);
    ev = '0; wr = 1'b0;
    reg_read(LB + 2*1, v);       check("R3 set beats clear", v, 4);
    reg_write(LB + 2*1, 4);

    // R9: bus activity caught while the clock is stopped.
    @(negedge clk);
    clk_en = 1'b0;
    #50 bus_line = 1'b1;
    #50 bus_line = 1'b0;
    #50 clk_en = 1'b1;
    repeat (5) @(negedge clk);
    reg_read(LB, v);             check("R9 bus wake", v, 1);
    check("R9 bus wake irq", int'(irq), 1);
    reg_write(LB, 1);
    repeat (4) @(negedge clk);
    reg_read(LB, v);             check("R9 single event", v, 0);

    // R10: pin low sets bit 1 once.
    @(negedge clk);
    wake_pin_n = 1'b0;
    repeat (5) @(negedge clk);
    reg_read(LB, v);             check("R10 pin wake", v, 2);
    reg_write(LB, 2);
    repeat (6) @(negedge clk);
    reg_read(LB, v);             check("R10 held low no repeat", v, 0);
    wake_pin_n = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule